// File: doc/BRIEF.md
# Capability Memory Access Checker

This block sits between the load-store unit and the memory port of a 32-bit core in which every load and store is authorized by a capability operand. No access path uses a bare integer address. For each request, the block receives the following inputs:

- the decoded authorizing capability: tag, sealed flag, permission bits, base, top and address;
- the access width and direction;
- whether the access moves a whole capability;
- for capability stores, the tag and global bit of the value being written.

One clock later it either grants the access or reports a fault with a cause code. When it grants a store, it also gives the tag bit that the written memory location must take.

Faults are ranked by fixed priority, and only the highest-ranked one is reported. The rules it enforces are: an untagged authority; a sealed authority; missing or contradictory permissions, including an attempt to store a local capability without store-local rights; an access that leaves the bounds; and a misaligned capability-width access. Bounds arithmetic uses one extra bit, so an access that ends exactly at the top of the address space is legal and none can wrap.

Top module: `capgate_top`

## Requirements
- R1: Each cycle with `req_i` high produces `rsp_valid_o` high exactly one cycle later. A cycle without a request gives `rsp_valid_o`, `grant_o`, `fault_o` and `tag_bit_o` low and `cause_o` zero in the following cycle.
- R2: An authority with its tag clear faults with cause 1. This outranks every other fault.
- R3: A tagged but sealed authority faults with cause 2.
- R4: The permission bits are: bit0 load, bit1 store, bit2 execute, bit3 load-capability, bit4 store-capability, bit5 store-local, bit6 global, bit7 seal/unseal. A data load needs bit0. A data store needs bit1. A capability load needs bits 0 and 3. A capability store needs bits 1 and 4. A missing bit faults with cause 3.
- R5: An authority holding both store (bit1) and execute (bit2) is malformed and faults with cause 3. So is an authority holding seal (bit7) together with any of bits 0 to 2.
- R6: A capability store of a tagged value whose global bit is clear faults with cause 3 unless the authority holds store-local (bit5). An untagged stored value is exempt from this rule.
- R7: The access passes the bounds check only if base <= address and address + width <= top. The sum uses 33-bit arithmetic and `auth_top_i` is 33 bits wide. A failure faults with cause 4.
- R8: Capability accesses are 8 bytes wide regardless of `size_i`, and their address must be a multiple of 8, otherwise the access faults with cause 5. Data accesses are `1 << size_i` bytes and have no alignment rule.
- R9: Fault priority is tag, seal, permission, bounds, alignment. `grant_o` is high only when there is no fault, and `fault_o` is high exactly when `cause_o` is non-zero.
- R10: A granted capability store sets `tag_bit_o` to the stored value's tag. A data store, any load and any faulted access give `tag_bit_o` = 0, so a data store always clears the location's tag.
- R11: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request this cycle |
| is_store_i | input | 1 | 1 = store, 0 = load |
| is_cap_i | input | 1 | Access moves a whole capability |
| size_i | input | 2 | Data width code, bytes = 1 << size_i |
| auth_tag_i | input | 1 | Authority validity tag |
| auth_sealed_i | input | 1 | Authority is sealed |
| auth_perm_i | input | 8 | Authority permission bits |
| auth_base_i | input | 32 | Decoded lower bound |
| auth_top_i | input | 33 | Decoded upper bound (exclusive) |
| auth_addr_i | input | 32 | Access address |
| src_tag_i | input | 1 | Tag of the capability being stored |
| src_global_i | input | 1 | Global bit of the capability being stored |
| rsp_valid_o | output | 1 | Result valid |
| grant_o | output | 1 | Access may proceed |
| fault_o | output | 1 | Access faulted |
| cause_o | output | 3 | Fault cause code, 0 when none |
| tag_bit_o | output | 1 | Tag value for the stored location |

## Verification
Every result is available one clock edge after the request. The request is presented in one cycle and all outputs register on the next rising edge. The bench drives inputs on a falling edge, lets exactly one rising edge pass, and samples all outputs on the next falling edge. It then drops the request and checks the idle response one cycle later. The vector table places several faults together in one request, so the priority order is checked on the same edge as the single-fault cases.

// File: rtl/capgate_pkg.sv
package capgate_pkg;
  localparam int unsigned PERM_W = 8;
  localparam int unsigned P_LD   = 0;
  localparam int unsigned P_ST   = 1;
  localparam int unsigned P_EX   = 2;
  localparam int unsigned P_LC   = 3;
  localparam int unsigned P_SC   = 4;
  localparam int unsigned P_SL   = 5;
  localparam int unsigned P_GL   = 6;
  localparam int unsigned P_SE   = 7;
  localparam int unsigned CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CZ_NONE   = 3'd0,
    CZ_TAG    = 3'd1,
    CZ_SEAL   = 3'd2,
    CZ_PERM   = 3'd3,
    CZ_BOUNDS = 3'd4,
    CZ_ALIGN  = 3'd5
  } cause_e;

  typedef struct packed {
    logic tag_bad;
    logic seal_bad;
    logic perm_bad;
    logic bounds_bad;
    logic align_bad;
  } fault_vec_t;

  function automatic cause_e rank_fault(input fault_vec_t f);
    if (f.tag_bad)         return CZ_TAG;
    else if (f.seal_bad)   return CZ_SEAL;
    else if (f.perm_bad)   return CZ_PERM;
    else if (f.bounds_bad) return CZ_BOUNDS;
    else if (f.align_bad)  return CZ_ALIGN;
    else                   return CZ_NONE;
  endfunction
endpackage

// File: rtl/capgate_perm.sv
module capgate_perm
  import capgate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PERM_W-1:0] perm_i,
  input  logic              is_store_i,
  input  logic              is_cap_i,
  input  logic              src_tag_i,
  input  logic              src_global_i,
  output logic              missing_o,
  output logic              malformed_o,
  output logic              local_bad_o,
  output logic              perm_bad_o
);
  logic [PERM_W-1:0] need;

  always_comb begin
    need = '0;
    if (is_store_i) need[P_ST] = 1'b1;
    else            need[P_LD] = 1'b1;
    if (is_cap_i) begin
      if (is_store_i) need[P_SC] = 1'b1;
      else            need[P_LC] = 1'b1;
    end
  end

  assign missing_o   = |(need & ~perm_i);
  assign malformed_o = (perm_i[P_ST] & perm_i[P_EX]) |
                       (perm_i[P_SE] & (perm_i[P_LD] | perm_i[P_ST] | perm_i[P_EX]));
  assign local_bad_o = is_store_i & is_cap_i & src_tag_i & ~src_global_i & ~perm_i[P_SL];
  assign perm_bad_o  = missing_o | malformed_o | local_bad_o;

  // R5: a write-and-execute authority never counts as permitted
  a_r5_no_wx_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_i[P_ST] && perm_i[P_EX]) |-> perm_bad_o);
  // R4: a store without store rights is never permitted
  a_r4_store_needs_st: assert property (@(posedge clk) disable iff (!rst_n)
    (is_store_i && !perm_i[P_ST]) |-> perm_bad_o);
endmodule

// File: rtl/capgate_bounds.sv
module capgate_bounds #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CAP_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W:0]   top_i,
  input  logic [1:0]        size_i,
  input  logic              is_cap_i,
  output logic              oob_o,
  output logic              misalign_o
);
  localparam int unsigned ALIGN_BITS = $clog2(CAP_BYTES);

  function automatic logic [ADDR_W:0] span_bytes(input logic cap, input logic [1:0] sz);
    if (cap) return (ADDR_W+1)'(CAP_BYTES);
    else     return (ADDR_W+1)'(1) << sz;
  endfunction

  logic [ADDR_W:0] end_addr;
  logic            below_base;
  logic            past_top;

  assign end_addr   = {1'b0, addr_i} + span_bytes(is_cap_i, size_i);
  assign below_base = addr_i < base_i;
  assign past_top   = end_addr > top_i;
  assign oob_o      = below_base | past_top;

  generate
    if (ALIGN_BITS > 0) begin : g_align
      assign misalign_o = is_cap_i & (|addr_i[ALIGN_BITS-1:0]);
    end else begin : g_noalign
      assign misalign_o = 1'b0;
    end
  endgenerate

  // R7: an address below the base is always out of bounds
  a_r7_below_base: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i < base_i) |-> oob_o);
  // R8: data accesses never raise the alignment fault
  a_r8_data_free: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cap_i |-> !misalign_o);
endmodule

// File: rtl/capgate_prio.sv
module capgate_prio
  import capgate_pkg::*;
(
  input  fault_vec_t          faults_i,
  output logic [CAUSE_W-1:0]  cause_o,
  output logic                any_o
);
  cause_e c;
  assign c       = rank_fault(faults_i);
  assign cause_o = c;
  assign any_o   = |faults_i;
endmodule

// File: rtl/capgate_top.sv
module capgate_top
  import capgate_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CAP_BYTES = (2 * ADDR_W) / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic                is_store_i,
  input  logic                is_cap_i,
  input  logic [1:0]          size_i,
  input  logic                auth_tag_i,
  input  logic                auth_sealed_i,
  input  logic [PERM_W-1:0]   auth_perm_i,
  input  logic [ADDR_W-1:0]   auth_base_i,
  input  logic [ADDR_W:0]     auth_top_i,
  input  logic [ADDR_W-1:0]   auth_addr_i,
  input  logic                src_tag_i,
  input  logic                src_global_i,
  output logic                rsp_valid_o,
  output logic                grant_o,
  output logic                fault_o,
  output logic [CAUSE_W-1:0]  cause_o,
  output logic                tag_bit_o
);
  logic missing_w, malformed_w, local_bad_w, perm_bad_w;
  logic oob_w, misalign_w;
  fault_vec_t faults_w;
  logic [CAUSE_W-1:0] cause_w;
  logic any_fault_w;
  logic tag_next_w;

  capgate_perm u_perm (
    .clk          (clk),
    .rst_n        (rst_n),
    .perm_i       (auth_perm_i),
    .is_store_i   (is_store_i),
    .is_cap_i     (is_cap_i),
    .src_tag_i    (src_tag_i),
    .src_global_i (src_global_i),
    .missing_o    (missing_w),
    .malformed_o  (malformed_w),
    .local_bad_o  (local_bad_w),
    .perm_bad_o   (perm_bad_w)
  );

  capgate_bounds #(.ADDR_W(ADDR_W), .CAP_BYTES(CAP_BYTES)) u_bounds (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (auth_addr_i),
    .base_i     (auth_base_i),
    .top_i      (auth_top_i),
    .size_i     (size_i),
    .is_cap_i   (is_cap_i),
    .oob_o      (oob_w),
    .misalign_o (misalign_w)
  );

  assign faults_w.tag_bad    = ~auth_tag_i;
  assign faults_w.seal_bad   = auth_sealed_i;
  assign faults_w.perm_bad   = perm_bad_w;
  assign faults_w.bounds_bad = oob_w;
  assign faults_w.align_bad  = misalign_w;

  capgate_prio u_prio (
    .faults_i (faults_w),
    .cause_o  (cause_w),
    .any_o    (any_fault_w)
  );

  assign tag_next_w = is_store_i & is_cap_i & src_tag_i & ~any_fault_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      grant_o     <= 1'b0;
      fault_o     <= 1'b0;
      cause_o     <= '0;
      tag_bit_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_i;
      grant_o     <= req_i & ~any_fault_w;
      fault_o     <= req_i & any_fault_w;
      cause_o     <= req_i ? cause_w : '0;
      tag_bit_o   <= req_i & tag_next_w;
    end
  end

  // R1: one response per request, one cycle later
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> rsp_valid_o);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!rsp_valid_o && !grant_o && !fault_o && !tag_bit_o));
  // R2: untagged authority wins over every other fault
  a_r2_tag_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !auth_tag_i) |=> (cause_o == CZ_TAG));
  // R3: sealed authority reported when tag is valid
  a_r3_sealed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && auth_tag_i && auth_sealed_i) |=> (cause_o == CZ_SEAL));
  // R6: local capability through an authority lacking store-local traps
  a_r6_local_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && is_store_i && is_cap_i && src_tag_i && !src_global_i && !auth_perm_i[P_SL])
      |=> fault_o);
  // R9: grant and fault are exclusive and fault matches a non-zero cause
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_o && fault_o) && (fault_o == (cause_o != '0)));
  // R10: a tag is only written by a granted capability store
  a_r10_tag_src: assert property (@(posedge clk) disable iff (!rst_n)
    tag_bit_o |-> (grant_o && $past(is_store_i && is_cap_i && src_tag_i)));
endmodule

// File: tb/capgate_top_tb_top.sv
module capgate_top_tb_top;
  import capgate_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req, is_store, is_cap, a_tag, a_sealed, s_tag, s_glob;
  logic [1:0] size;
  logic [7:0] perm;
  logic [31:0] base, addr;
  logic [32:0] top;
  logic rsp_valid, grant, fault, tag_bit;
  logic [2:0] cause;

  capgate_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .is_store_i(is_store), .is_cap_i(is_cap),
    .size_i(size), .auth_tag_i(a_tag), .auth_sealed_i(a_sealed), .auth_perm_i(perm),
    .auth_base_i(base), .auth_top_i(top), .auth_addr_i(addr), .src_tag_i(s_tag),
    .src_global_i(s_glob), .rsp_valid_o(rsp_valid), .grant_o(grant), .fault_o(fault),
    .cause_o(cause), .tag_bit_o(tag_bit)
  );

  typedef struct packed {
    logic        tag;
    logic        sealed;
    logic [7:0]  perm;
    logic [31:0] base;
    logic [32:0] top;
    logic [31:0] addr;
    logic [1:0]  sz;
    logic        cap;
    logic        st;
    logic        stag;
    logic        sglob;
    logic [2:0]  cause;
    logic        tagw;
    logic [3:0]  req_id;
  } vec_t;

  localparam int NV = 21;
  localparam logic [31:0] B0 = 32'h0000_1000;
  localparam logic [32:0] T0 = 33'h0_0000_1100;
  localparam logic [32:0] TMAX = 33'h1_0000_0000;
  // req_id: requirement each vector targets
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,8'h43,B0,T0,32'h1000,2'd2,1'b0,1'b0,1'b0,1'b0,3'd1,1'b0,4'd2},
    '{1'b1,1'b1,8'h43,B0,T0,32'h1000,2'd2,1'b0,1'b0,1'b0,1'b0,3'd2,1'b0,4'd3},
    '{1'b0,1'b1,8'h06,B0,T0,32'h0FFF,2'd2,1'b1,1'b0,1'b0,1'b0,3'd1,1'b0,4'd9},
    '{1'b1,1'b0,8'h41,B0,T0,32'h1000,2'd2,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,4'd4},
    '{1'b1,1'b0,8'h41,B0,T0,32'h1000,2'd2,1'b0,1'b1,1'b0,1'b0,3'd3,1'b0,4'd4},
    '{1'b1,1'b0,8'h41,B0,T0,32'h10FC,2'd2,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,4'd7},
    '{1'b1,1'b0,8'h41,B0,T0,32'h10FD,2'd2,1'b0,1'b0,1'b0,1'b0,3'd4,1'b0,4'd7},
    '{1'b1,1'b0,8'h41,B0,T0,32'h0FFF,2'd0,1'b0,1'b0,1'b0,1'b0,3'd4,1'b0,4'd7},
    '{1'b1,1'b0,8'h49,B0,T0,32'h1008,2'd0,1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,4'd8},
    '{1'b1,1'b0,8'h49,B0,T0,32'h1004,2'd3,1'b1,1'b0,1'b0,1'b0,3'd5,1'b0,4'd8},
    '{1'b1,1'b0,8'h49,B0,T0,32'h10FC,2'd3,1'b1,1'b0,1'b0,1'b0,3'd4,1'b0,4'd9},
    '{1'b1,1'b0,8'h12,B0,T0,32'h1010,2'd3,1'b1,1'b1,1'b1,1'b1,3'd0,1'b1,4'd10},
    '{1'b1,1'b0,8'h12,B0,T0,32'h1010,2'd3,1'b1,1'b1,1'b1,1'b0,3'd3,1'b0,4'd6},
    '{1'b1,1'b0,8'h32,B0,T0,32'h1010,2'd3,1'b1,1'b1,1'b1,1'b0,3'd0,1'b1,4'd6},
    '{1'b1,1'b0,8'h12,B0,T0,32'h1010,2'd3,1'b1,1'b1,1'b0,1'b0,3'd0,1'b0,4'd6},
    '{1'b1,1'b0,8'h02,B0,T0,32'h1010,2'd2,1'b0,1'b1,1'b1,1'b1,3'd0,1'b0,4'd10},
    '{1'b1,1'b0,8'h07,B0,T0,32'h1000,2'd2,1'b0,1'b0,1'b0,1'b0,3'd3,1'b0,4'd5},
    '{1'b1,1'b0,8'h81,B0,T0,32'h1000,2'd2,1'b0,1'b0,1'b0,1'b0,3'd3,1'b0,4'd5},
    '{1'b1,1'b0,8'h41,32'h0,TMAX,32'hFFFF_FFFC,2'd2,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,4'd7},
    '{1'b1,1'b0,8'h41,32'h0,TMAX,32'hFFFF_FFFE,2'd2,1'b0,1'b0,1'b0,1'b0,3'd4,1'b0,4'd7},
    '{1'b1,1'b0,8'h02,B0,T0,32'h1010,2'd3,1'b1,1'b1,1'b1,1'b1,3'd3,1'b0,4'd4}
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req_tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req = 0; is_store = 0; is_cap = 0; size = 0; a_tag = 0; a_sealed = 0;
    perm = 0; base = 0; top = 0; addr = 0; s_tag = 0; s_glob = 0;
  endtask

  task automatic apply(input vec_t v);
    req = 1; a_tag = v.tag; a_sealed = v.sealed; perm = v.perm; base = v.base;
    top = v.top; addr = v.addr; size = v.sz; is_cap = v.cap; is_store = v.st;
    s_tag = v.stag; s_glob = v.sglob;
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset", {3'b0, rsp_valid, grant, fault, tag_bit, 1'b0}, 8'h00);
    chk("R11 reset cause", {5'b0, cause}, 8'h00);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: no request gives quiet outputs
    chk("R1 idle", {4'b0, rsp_valid, grant, fault, tag_bit}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tg;
      v = TBL[i];
      tg = $sformatf("R%0d vec%0d", v.req_id, i);
      apply(v);
      @(negedge clk);
      chk({tg, " cause"}, {5'b0, cause}, {5'b0, v.cause});
      chk({tg, " grant"}, {7'b0, grant}, {7'b0, (v.cause == 3'd0)});
      chk({tg, " fault"}, {7'b0, fault}, {7'b0, (v.cause != 3'd0)});
      chk({tg, " tag"}, {7'b0, tag_bit}, {7'b0, v.tagw});
      chk("R1 valid", {7'b0, rsp_valid}, 8'h01);
      idle_inputs();
      @(negedge clk);
      chk("R1 drop", {7'b0, rsp_valid}, 8'h00);
    end

    // R8: size_i ignored for capability access, 8-byte width reaches top
    apply(TBL[8]);
    perm = 8'h49; is_cap = 1; size = 2'd0; addr = 32'h10F8;
    @(negedge clk);
    chk("R8 cap width at top", {5'b0, cause}, 8'h00);
    idle_inputs();
    @(negedge clk);

    // R10: data store clears tag even with src tag set
    apply(TBL[15]);
    @(negedge clk);
    chk("R10 data store clears", {7'b0, tag_bit}, 8'h00);
    idle_inputs();
    @(negedge clk);

    // R11: reset mid-stream clears outputs
    apply(TBL[11]);
    rst_n = 0;
    @(negedge clk);
    chk("R11 reset clears", {4'b0, rsp_valid, grant, fault, tag_bit}, 8'h00);
    rst_n = 1;
    idle_inputs();
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule